// File: doc/BRIEF.md
# DisplayPort Link Rate and Lane Selector

This block picks the smallest DisplayPort main-link configuration that can carry a requested pixel clock. It reads the sink's capability revision, its maximum link-rate byte and its maximum lane-count byte. It cleans up any out-of-range values in those bytes, then searches lane counts and link rates one candidate per clock. The first candidate whose bandwidth covers the pixel stream is reported.

Software or a link-training sequencer drives a one-cycle `start` with the pixel clock in kHz and the three capability bytes. The inputs are captured on that edge. `busy` stays high while candidates are tried. The search then ends with a one-cycle `done` that carries either `valid` with the chosen lane count, rate code and link clock, or `fail` when no candidate fits.

Top module: `lane_rate_selector`

## Requirements
- R1: After reset, `busy`, `done`, `valid` and `fail` are 0, and `lane_cnt`, `rate_code` and `link_khz` are 0.
- R2: Rate code 0x06 is reported with `link_khz` = 162000, and rate code 0x0a is reported with `link_khz` = 270000.
- R3: The high rate (0x0a) is tried only when the maximum link-rate byte equals 0x0a. Any other byte value, including invalid ones, limits the search to 0x06.
- R4: When the revision byte is 0x11 or above, the lane limit is bits [4:0] of the lane-count byte. A field value other than 1, 2 or 4 is treated as 4, and bits [7:5] are ignored.
- R5: When the revision byte is below 0x11, the lane limit is 4 whatever the lane-count byte holds.
- R6: Candidates are tried in this order: lanes 1, 2, 4 in the outer loop, and within each lane count 0x06 first, then 0x0a if allowed. The first candidate with pixel_khz*3 <= link_khz*lanes is chosen, so equality fits.
- R7: One candidate is evaluated per clock. `done` rises n clock edges after the edge that sampled `start`, where n is the 1-based position of the chosen candidate, or the number of allowed candidates on failure.
- R8: `done` is a one-cycle pulse. On success it comes with `valid`=1 and `fail`=0, and the result outputs update on that same edge.
- R9: When no candidate fits, `done` comes with `fail`=1 and `valid`=0, and `lane_cnt`, `rate_code` and `link_khz` keep their previous values.
- R10: A `start` that arrives while `busy` is high is ignored. It neither restarts the search nor causes a later extra `done`.
- R11: Pixel clocks up to 600000 kHz are handled without overflow. 360000 kHz fits on 4 lanes at 0x0a, and 360001 and 600000 kHz fail.
- R12: The pixel clock and capability bytes are sampled on the `start` edge. Changing them during a search does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| pix_khz | input | 20 | Requested pixel clock in kHz |
| cap_rev | input | 8 | Sink capability revision byte |
| cap_rate | input | 8 | Sink maximum link-rate byte |
| cap_lanes | input | 8 | Sink maximum lane-count byte |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| valid | output | 1 | With done: a configuration was found |
| fail | output | 1 | With done: no configuration fits |
| lane_cnt | output | 3 | Chosen lane count (1, 2 or 4) |
| rate_code | output | 8 | Chosen link-rate code (0x06 or 0x0a) |
| link_khz | output | 19 | Chosen link clock in kHz |

## Verification
The assertions assume `pix_khz` stays within its 20-bit range and that `start` is a clean synchronous pulse. With those inputs, the search can never run past six candidates, and a valid result always has enough bandwidth for the latched pixel clock. The stimulus drives `start` and all data inputs only at falling clock edges and keeps pixel clocks at or below 600000 kHz. It deliberately changes inputs and pulses `start` mid-search, so that the assumed capture behaviour is actually exercised rather than just taken for granted.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

  localparam logic [7:0]  CODE_LO       = 8'h06;
  localparam logic [7:0]  CODE_HI       = 8'h0a;
  localparam int unsigned KHZ_LO        = 162000;
  localparam int unsigned KHZ_HI        = 270000;
  localparam logic [7:0]  REV_LANE_FLD  = 8'h11;
  localparam int unsigned PIX_MULT      = 3;
  localparam int unsigned MAX_CANDIDATE = 6;

  typedef enum logic [0:0] {ST_IDLE, ST_SEARCH} srch_state_e;

  // true only for a sink that advertises the high rate
  function automatic logic rate_hi_allowed(input logic [7:0] rate_byte);
    return rate_byte == CODE_HI;
  endfunction

  // lane ceiling derived from revision and lane-count byte
  function automatic logic [2:0] lane_ceiling(input logic [7:0] rev,
                                              input logic [7:0] lanes_byte);
    logic [4:0] fld;
    fld = lanes_byte[4:0];
    if (rev < REV_LANE_FLD) return 3'd4;
    case (fld)
      5'd1:    return 3'd1;
      5'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] rate_khz(input logic hi);
    return hi ? 32'(KHZ_HI) : 32'(KHZ_LO);
  endfunction

  function automatic logic [7:0] rate_code_of(input logic hi);
    return hi ? CODE_HI : CODE_LO;
  endfunction

endpackage

// File: rtl/lsel_cap_filter.sv
module lsel_cap_filter
  import lsel_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic [7:0]        cap_rev,
  input  logic [7:0]        cap_rate,
  input  logic [7:0]        cap_lanes,
  output logic              hi_ok,
  output logic [LANE_W-1:0] lane_max
);
  logic [2:0] ceil3;

  always_comb begin
    hi_ok = rate_hi_allowed(cap_rate);
    ceil3 = lane_ceiling(cap_rev, cap_lanes);
  end

  generate
    if (LANE_W > 3) begin : g_wide
      assign lane_max = {{(LANE_W-3){1'b0}}, ceil3};
    end else begin : g_exact
      assign lane_max = ceil3[LANE_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lsel_fit_eval.sv
module lsel_fit_eval
  import lsel_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int KHZ_W  = 19,
  parameter int LANE_W = 3,
  parameter int BW_W   = 22
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LANE_W-1:0] lanes,
  input  logic              hi,
  output logic [KHZ_W-1:0]  cand_khz,
  output logic [7:0]        cand_code,
  output logic [BW_W-1:0]   need_bw,
  output logic [BW_W-1:0]   have_bw,
  output logic              fits
);
  logic [31:0] khz32;

  always_comb begin
    khz32     = rate_khz(hi);
    cand_khz  = khz32[KHZ_W-1:0];
    cand_code = rate_code_of(hi);
    need_bw   = BW_W'(pix) * BW_W'(PIX_MULT);
    have_bw   = BW_W'(cand_khz) * BW_W'(lanes);
    fits      = need_bw <= have_bw;
  end
endmodule

// File: rtl/lsel_search_ctl.sv
module lsel_search_ctl
  import lsel_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int KHZ_W  = 19,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              hi_ok_in,
  input  logic [LANE_W-1:0] lane_max_in,
  input  logic              fits,
  input  logic [KHZ_W-1:0]  cand_khz,
  input  logic [7:0]        cand_code,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LANE_W-1:0] cur_lanes,
  output logic              cur_hi,
  output logic              launch,
  output logic              last_cand,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic              fail,
  output logic [LANE_W-1:0] lane_cnt,
  output logic [7:0]        rate_code,
  output logic [KHZ_W-1:0]  link_khz
);
  srch_state_e      state;
  logic             hi_ok_q;
  logic [LANE_W-1:0] lane_max_q;

  assign busy      = (state == ST_SEARCH);
  assign launch    = start && (state == ST_IDLE);
  assign last_cand = (cur_hi || !hi_ok_q) && (cur_lanes >= lane_max_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pix_q      <= '0;
      hi_ok_q    <= 1'b0;
      lane_max_q <= '0;
      cur_lanes  <= '0;
      cur_hi     <= 1'b0;
      done       <= 1'b0;
      valid      <= 1'b0;
      fail       <= 1'b0;
      lane_cnt   <= '0;
      rate_code  <= '0;
      link_khz   <= '0;
    end else begin
      done  <= 1'b0;
      valid <= 1'b0;
      fail  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            pix_q      <= pix_in;
            hi_ok_q    <= hi_ok_in;
            lane_max_q <= lane_max_in;
            cur_lanes  <= LANE_W'(1);
            cur_hi     <= 1'b0;
            state      <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (fits) begin
            done      <= 1'b1;
            valid     <= 1'b1;
            lane_cnt  <= cur_lanes;
            rate_code <= cand_code;
            link_khz  <= cand_khz;
            state     <= ST_IDLE;
          end else if (last_cand) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= ST_IDLE;
          end else if (!cur_hi && hi_ok_q) begin
            cur_hi <= 1'b1;
          end else begin
            cur_lanes <= cur_lanes << 1;
            cur_hi    <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_rate_selector.sv
module lane_rate_selector
  import lsel_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int KHZ_W  = 19,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PIX_W-1:0]  pix_khz,
  input  logic [7:0]        cap_rev,
  input  logic [7:0]        cap_rate,
  input  logic [7:0]        cap_lanes,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic              fail,
  output logic [LANE_W-1:0] lane_cnt,
  output logic [7:0]        rate_code,
  output logic [KHZ_W-1:0]  link_khz
);
  localparam int NEED_W = PIX_W + 2;
  localparam int HAVE_W = KHZ_W + LANE_W;
  localparam int BW_W   = (NEED_W > HAVE_W) ? NEED_W : HAVE_W;

  logic              hi_ok;
  logic [LANE_W-1:0] lane_max;
  logic [PIX_W-1:0]  pix_q;
  logic [LANE_W-1:0] cur_lanes;
  logic              cur_hi;
  logic              launch;
  logic              last_cand;
  logic [KHZ_W-1:0]  cand_khz;
  logic [7:0]        cand_code;
  logic [BW_W-1:0]   need_bw;
  logic [BW_W-1:0]   have_bw;
  logic              fits;

  lsel_cap_filter #(.LANE_W(LANE_W)) u_caps (
    .cap_rev   (cap_rev),
    .cap_rate  (cap_rate),
    .cap_lanes (cap_lanes),
    .hi_ok     (hi_ok),
    .lane_max  (lane_max)
  );

  lsel_fit_eval #(.PIX_W(PIX_W), .KHZ_W(KHZ_W), .LANE_W(LANE_W), .BW_W(BW_W)) u_fit (
    .pix       (pix_q),
    .lanes     (cur_lanes),
    .hi        (cur_hi),
    .cand_khz  (cand_khz),
    .cand_code (cand_code),
    .need_bw   (need_bw),
    .have_bw   (have_bw),
    .fits      (fits)
  );

  lsel_search_ctl #(.PIX_W(PIX_W), .KHZ_W(KHZ_W), .LANE_W(LANE_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pix_in      (pix_khz),
    .hi_ok_in    (hi_ok),
    .lane_max_in (lane_max),
    .fits        (fits),
    .cand_khz    (cand_khz),
    .cand_code   (cand_code),
    .pix_q       (pix_q),
    .cur_lanes   (cur_lanes),
    .cur_hi      (cur_hi),
    .launch      (launch),
    .last_cand   (last_cand),
    .busy        (busy),
    .done        (done),
    .valid       (valid),
    .fail        (fail),
    .lane_cnt    (lane_cnt),
    .rate_code   (rate_code),
    .link_khz    (link_khz)
  );
endmodule

// File: rtl/lsel_checker.sv
module lsel_checker
  import lsel_pkg::*;
#(
  parameter int PIX_W  = 20,
  parameter int KHZ_W  = 19,
  parameter int LANE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              launch,
  input logic              busy,
  input logic              done,
  input logic              valid,
  input logic              fail,
  input logic [PIX_W-1:0]  pix_q,
  input logic [LANE_W-1:0] lane_cnt,
  input logic [7:0]        rate_code,
  input logic [KHZ_W-1:0]  link_khz
);
  logic [31:0] need32;
  logic [31:0] have32;
  logic [3:0]  run_len;

  always_comb begin
    need32 = 32'(pix_q) * 32'd3;
    have32 = 32'(link_khz) * 32'(lane_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 4'd1;
    else           run_len <= '0;
  end

  // R8
  done_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (valid ^ fail));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  fit_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (need32 <= have32));

  // R2
  rate_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((rate_code == CODE_HI && link_khz == KHZ_W'(KHZ_HI)) ||
               (rate_code == CODE_LO && link_khz == KHZ_W'(KHZ_LO))));

  // R4
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($onehot(lane_cnt) && lane_cnt <= LANE_W'(4)));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ($stable(lane_cnt) && $stable(rate_code) && $stable(link_khz)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pix_q));

  // R7
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 4'(MAX_CANDIDATE));
endmodule

bind lane_rate_selector lsel_checker #(.PIX_W(PIX_W), .KHZ_W(KHZ_W), .LANE_W(LANE_W)) u_lsel_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .launch    (launch),
  .busy      (busy),
  .done      (done),
  .valid     (valid),
  .fail      (fail),
  .pix_q     (pix_q),
  .lane_cnt  (lane_cnt),
  .rate_code (rate_code),
  .link_khz  (link_khz)
);

// File: tb/test_lane_rate_selector.sv
`timescale 1ns/1ps
module test_lane_rate_selector;

  typedef struct packed {
    logic [7:0]  rev;
    logic [7:0]  rate;
    logic [7:0]  lanes;
    logic [19:0] pix;
    logic        ok;
    logic [2:0]  el;
    logic [7:0]  ec;
    logic [18:0] ek;
    logic [3:0]  cyc;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{8'h11, 8'h0a, 8'h04, 20'd54000,  1'b1, 3'd1, 8'h06, 19'd162000, 4'd1, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd54001,  1'b1, 3'd1, 8'h0a, 19'd270000, 4'd2, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd90000,  1'b1, 3'd1, 8'h0a, 19'd270000, 4'd2, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd90001,  1'b1, 3'd2, 8'h06, 19'd162000, 4'd3, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd108001, 1'b1, 3'd2, 8'h0a, 19'd270000, 4'd4, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd180000, 1'b1, 3'd2, 8'h0a, 19'd270000, 4'd4, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd180001, 1'b1, 3'd4, 8'h06, 19'd162000, 4'd5, 4'd6},
    '{8'h11, 8'h0a, 8'h04, 20'd216001, 1'b1, 3'd4, 8'h0a, 19'd270000, 4'd6, 4'd7},
    '{8'h11, 8'h0a, 8'h04, 20'd360000, 1'b1, 3'd4, 8'h0a, 19'd270000, 4'd6, 4'd11},
    '{8'h11, 8'h0a, 8'h04, 20'd360001, 1'b0, 3'd0, 8'h00, 19'd0,      4'd6, 4'd11},
    '{8'h11, 8'h0a, 8'h04, 20'd600000, 1'b0, 3'd0, 8'h00, 19'd0,      4'd6, 4'd11},
    '{8'h11, 8'h06, 8'h04, 20'd54001,  1'b1, 3'd2, 8'h06, 19'd162000, 4'd2, 4'd3},
    '{8'h11, 8'h06, 8'h04, 20'd216000, 1'b1, 3'd4, 8'h06, 19'd162000, 4'd3, 4'd6},
    '{8'h11, 8'h06, 8'h04, 20'd216001, 1'b0, 3'd0, 8'h00, 19'd0,      4'd3, 4'd9},
    '{8'h11, 8'h14, 8'h04, 20'd54001,  1'b1, 3'd2, 8'h06, 19'd162000, 4'd2, 4'd3},
    '{8'h10, 8'h0a, 8'h01, 20'd180001, 1'b1, 3'd4, 8'h06, 19'd162000, 4'd5, 4'd5},
    '{8'h12, 8'h0a, 8'h81, 20'd54001,  1'b1, 3'd1, 8'h0a, 19'd270000, 4'd2, 4'd4},
    '{8'h12, 8'h0a, 8'h81, 20'd90001,  1'b0, 3'd0, 8'h00, 19'd0,      4'd2, 4'd4},
    '{8'h11, 8'h0a, 8'h02, 20'd180001, 1'b0, 3'd0, 8'h00, 19'd0,      4'd4, 4'd4},
    '{8'h11, 8'h0a, 8'h03, 20'd180001, 1'b1, 3'd4, 8'h06, 19'd162000, 4'd5, 4'd4},
    '{8'h11, 8'h0a, 8'h22, 20'd108001, 1'b1, 3'd2, 8'h0a, 19'd270000, 4'd4, 4'd4},
    '{8'h00, 8'h06, 8'h00, 20'd0,      1'b1, 3'd1, 8'h06, 19'd162000, 4'd1, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pix_khz = '0;
  logic [7:0]  cap_rev = '0;
  logic [7:0]  cap_rate = '0;
  logic [7:0]  cap_lanes = '0;
  logic        busy, done, valid, fail;
  logic [2:0]  lane_cnt;
  logic [7:0]  rate_code;
  logic [18:0] link_khz;

  int errors = 0;
  int checks = 0;
  logic [2:0]  hold_l = '0;
  logic [7:0]  hold_c = '0;
  logic [18:0] hold_k = '0;

  always #5 clk = ~clk;

  lane_rate_selector i_lane_rate_selector (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
    .cap_rev(cap_rev), .cap_rate(cap_rate), .cap_lanes(cap_lanes),
    .busy(busy), .done(done), .valid(valid), .fail(fail),
    .lane_cnt(lane_cnt), .rate_code(rate_code), .link_khz(link_khz)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd7:    return "R7";
      4'd9:    return "R9";
      4'd11:   return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch_run(input logic [7:0] rv, input logic [7:0] rt,
                            input logic [7:0] ln, input logic [19:0] px,
                            output int cyc);
    @(negedge clk);
    cap_rev = rv; cap_rate = rt; cap_lanes = ln; pix_khz = px;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 20; k++) begin
      if (k > 0 || 1) begin
        @(negedge clk);
        cyc++;
        if (done) break;
      end
    end
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int extra;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && valid == 0 && fail == 0, "R1", "flags", {busy, done, valid, fail}, 0);
    check(lane_cnt == 0 && rate_code == 0 && link_khz == 0, "R1", "result regs", link_khz, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch_run(VEC[i].rev, VEC[i].rate, VEC[i].lanes, VEC[i].pix, cyc);
      check(done == 1'b1, "R8", "done seen", done, 1);
      check(cyc == int'(VEC[i].cyc), "R7", "cycles to done", cyc, VEC[i].cyc);
      if (VEC[i].ok) begin
        check(valid == 1 && fail == 0, "R8", "valid/fail", {valid, fail}, 2);
        check(lane_cnt == VEC[i].el, tag_name(VEC[i].tag), "lanes", lane_cnt, VEC[i].el);
        check(rate_code == VEC[i].ec, tag_name(VEC[i].tag), "rate code", rate_code, VEC[i].ec);
        // R2 rate to clock mapping
        check(link_khz == VEC[i].ek, "R2", "link khz", link_khz, VEC[i].ek);
        hold_l = VEC[i].el; hold_c = VEC[i].ec; hold_k = VEC[i].ek;
      end else begin
        // R9 fail path keeps previous result
        check(valid == 0 && fail == 1, "R9", "valid/fail", {valid, fail}, 1);
        check(lane_cnt == hold_l && rate_code == hold_c && link_khz == hold_k,
              "R9", "held khz", link_khz, hold_k);
      end
      @(negedge clk);
      check(done == 0 && valid == 0 && fail == 0, "R8", "pulse width", {done, valid, fail}, 0);
    end

    // R10: start while busy is ignored
    @(negedge clk);
    cap_rev = 8'h11; cap_rate = 8'h0a; cap_lanes = 8'h04; pix_khz = 20'd600000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b1; pix_khz = 20'd0;
    @(negedge clk);
    start = 1'b0;
    extra = 0;
    cyc = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    check(cyc == 6 && fail == 1, "R10", "first search unchanged", cyc, 6);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R10", "extra done pulses", extra, 0);

    // R12: inputs changed mid-search do not matter
    @(negedge clk);
    cap_rev = 8'h11; cap_rate = 8'h0a; cap_lanes = 8'h04; pix_khz = 20'd180001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; pix_khz = 20'd0; cap_lanes = 8'h01; cap_rate = 8'h06;
    cyc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    check(cyc == 5 && valid == 1, "R12", "cycles", cyc, 5);
    check(lane_cnt == 3'd4 && rate_code == 8'h06, "R12", "lanes", lane_cnt, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule